// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Tracker

This block is the processor-facing half of an interrupt controller. It keeps track of which interrupt the processor is servicing and at what priority. It also keeps track of the interrupts that the current one preempted. A separate priority search supplies the ID and priority of the best pending interrupt. Reading the acknowledge register claims that interrupt when it is strictly more urgent than the running one. The block then emits a one-cycle claim pulse, which tells the pending logic to drop the request line and clear the pending bit.

Every claim saves the preempted running ID and priority in a per-ID link entry. The active interrupts therefore form a stack that is threaded through the link table. An end-of-interrupt write for the running ID pops that stack in one cycle. An end-of-interrupt write for any other ID starts a walk along the chain, visiting one link per cycle. During the walk the bus is held off, and the entry that points at the retired ID is spliced past it. The block also holds the CPU enable bit and the priority mask, and reports the running priority and the highest pending ID.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, the priority mask is 0xF0, the CPU enable is 0 and `bus_ready` is 1.
- R2: An access is accepted on a clock edge where `bus_valid` and `bus_ready` are both 1, and read data is valid in that same cycle. The registers are:
  - offset 0x00: CPU enable in bit 0, read/write.
  - offset 0x04: priority mask. A write keeps only data bits 9:0.
  - offset 0x14: running priority, read only.
  - offset 0x18: the highest pending ID input, read only.
- R3: A read of offset 0x0C succeeds when the pending ID is below the interrupt count and the pending priority is strictly below the running priority. It then returns the pending ID and pulses `claim_valid` with `claim_id` for that cycle. From the next cycle the running ID and priority are the claimed ID and its priority.
- R4: A read of offset 0x0C returns 1023 with no claim pulse and no change of running state in three cases: the pending ID is 1023, the pending ID is not below the interrupt count, or the pending priority is not strictly below the running priority.
- R5: Whenever the running ID is 1023, the running priority is 0x100.
- R6: A write to offset 0x10 while the running ID is 1023 changes nothing, and `bus_ready` stays 1.
- R7: A write to offset 0x10 whose data bits 9:0 equal the running ID restores the ID and priority that were running when that ID was claimed. The restore takes effect in the next cycle, with no busy cycle.
- R8: A write to offset 0x10 naming a different active ID leaves the running ID and priority unchanged. It drops `bus_ready` for one cycle per link visited, starting from the running ID's link up to and including the link that names the retired ID. Later restores then skip the retired ID.
- R9: A write to offset 0x10 naming an ID that is not on the active chain walks the whole chain, spending one busy cycle per link up to the terminating 1023, and changes no running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted this cycle when high together with `bus_valid` |
| bus_rdata | output | 32 | Read data, valid in the accepting cycle |
| pend_id | input | 10 | Highest pending interrupt ID from the priority search |
| pend_prio | input | 8 | Priority of `pend_id` (lower is more urgent) |
| claim_valid | output | 1 | One-cycle pulse on a successful acknowledge |
| claim_id | output | 10 | ID being claimed |
| cpu_en | output | 1 | CPU interface enable bit |
| prio_mask | output | 10 | Priority mask register |
| run_id | output | 10 | Running interrupt ID (1023 when none) |
| run_prio | output | 9 | Running priority (0x100 when none) |

## Verification
Four properties are checked on every cycle:
- the idle-priority invariant;
- a claim lowering the running priority and installing the claimed ID;
- a refused acknowledge reading 1023;
- running state staying fixed during a walk and after an end-of-interrupt with nothing active.

Only the directed scenarios can show the content of the link chain. That covers restoring the right preempted interrupt, the exact count of busy cycles for a splice at each depth and for a miss, and later restores skipping the retired ID.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    parameter int ID_W   = 10;
    parameter int PRIO_W = 8;
    parameter int RP_W   = PRIO_W + 1;

    typedef logic [ID_W-1:0] irq_id_t;
    typedef logic [RP_W-1:0] run_prio_t;

    localparam irq_id_t   NO_IRQ    = irq_id_t'((1 << ID_W) - 1);
    localparam run_prio_t IDLE_PRIO = run_prio_t'(1 << PRIO_W);
    localparam logic [ID_W-1:0] MASK_RST = ID_W'(8'hF0);

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MASK = 8'h04;
    localparam logic [7:0] OFS_ACK  = 8'h0C;
    localparam logic [7:0] OFS_EOI  = 8'h10;
    localparam logic [7:0] OFS_RUNP = 8'h14;
    localparam logic [7:0] OFS_PEND = 8'h18;

    typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;

    typedef struct packed {
        irq_id_t   id;
        run_prio_t prio;
    } link_ent_t;

    typedef struct packed {
        walk_st_e        st;
        logic            en;
        logic [ID_W-1:0] mask;
        irq_id_t         run_id;
        run_prio_t       run_prio;
        irq_id_t         cur;
        irq_id_t         tgt;
    } ctl_t;
endpackage

// File: rtl/irq_link_table.sv
module irq_link_table
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 96
) (
    input  logic      clk,
    input  logic      we,
    input  irq_id_t   waddr,
    input  link_ent_t wdata,
    input  irq_id_t   raddr_a,
    output link_ent_t rdata_a,
    input  irq_id_t   raddr_b,
    output link_ent_t rdata_b
);
    localparam int IDX_W = $clog2(NUM_IRQ);
    localparam link_ent_t EMPTY = '{id: NO_IRQ, prio: IDLE_PRIO};

    link_ent_t mem_q [NUM_IRQ];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < NUM_IRQ))
            mem_q[waddr[IDX_W-1:0]] <= wdata;
    end

    assign rdata_a = (int'(raddr_a) < NUM_IRQ) ? mem_q[raddr_a[IDX_W-1:0]] : EMPTY;
    assign rdata_b = (int'(raddr_b) < NUM_IRQ) ? mem_q[raddr_b[IDX_W-1:0]] : EMPTY;
endmodule

// File: rtl/irq_ack_judge.sv
module irq_ack_judge
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 96
) (
    input  irq_id_t           pend_id,
    input  logic [PRIO_W-1:0] pend_prio,
    input  run_prio_t         run_prio,
    output logic              grant
);
    logic id_ok;
    logic preempts;

    assign id_ok    = (pend_id != NO_IRQ) && (int'(pend_id) < NUM_IRQ);
    assign preempts = ({1'b0, pend_prio} < run_prio);
    assign grant    = id_ok && preempts;
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [ID_W-1:0]   pend_id,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              claim_valid,
    output logic [ID_W-1:0]   claim_id,
    output logic              cpu_en,
    output logic [ID_W-1:0]   prio_mask,
    output logic [ID_W-1:0]   run_id,
    output logic [RP_W-1:0]   run_prio
);
    ctl_t ctl_q, ctl_d;

    logic      grant;
    logic      lt_we;
    irq_id_t   lt_waddr, lt_raddr_a;
    link_ent_t lt_wdata, lt_rdata_a, lt_rdata_b;
    logic      acc;
    irq_id_t   eoi_id;
    logic [7:0] ofs;

    irq_ack_judge #(.NUM_IRQ(NUM_IRQ)) u_judge (
        .pend_id  (pend_id),
        .pend_prio(pend_prio),
        .run_prio (ctl_q.run_prio),
        .grant    (grant)
    );

    irq_link_table #(.NUM_IRQ(NUM_IRQ)) u_links (
        .clk    (clk),
        .we     (lt_we),
        .waddr  (lt_waddr),
        .wdata  (lt_wdata),
        .raddr_a(lt_raddr_a),
        .rdata_a(lt_rdata_a),
        .raddr_b(ctl_q.tgt),
        .rdata_b(lt_rdata_b)
    );

    assign bus_ready  = (ctl_q.st == ST_IDLE);
    assign acc        = bus_valid && bus_ready;
    assign eoi_id     = bus_wdata[ID_W-1:0];
    assign ofs        = 8'(bus_addr);
    assign lt_raddr_a = (ctl_q.st == ST_WALK) ? ctl_q.cur : ctl_q.run_id;

    always_comb begin
        ctl_d       = ctl_q;
        bus_rdata   = '0;
        claim_valid = 1'b0;
        claim_id    = pend_id;
        lt_we       = 1'b0;
        lt_waddr    = pend_id;
        lt_wdata    = '{id: ctl_q.run_id, prio: ctl_q.run_prio};

        if (ctl_q.st == ST_IDLE) begin
            if (acc && !bus_write) begin
                case (ofs)
                    OFS_CTRL: bus_rdata = DATA_W'(ctl_q.en);
                    OFS_MASK: bus_rdata = DATA_W'(ctl_q.mask);
                    OFS_RUNP: bus_rdata = DATA_W'(ctl_q.run_prio);
                    OFS_PEND: bus_rdata = DATA_W'(pend_id);
                    OFS_ACK: begin
                        if (grant) begin
                            bus_rdata      = DATA_W'(pend_id);
                            claim_valid    = 1'b1;
                            lt_we          = 1'b1;
                            ctl_d.run_id   = pend_id;
                            ctl_d.run_prio = {1'b0, pend_prio};
                        end else begin
                            bus_rdata = DATA_W'(NO_IRQ);
                        end
                    end
                    default: bus_rdata = '0;
                endcase
            end else if (acc && bus_write) begin
                case (ofs)
                    OFS_CTRL: ctl_d.en   = bus_wdata[0];
                    OFS_MASK: ctl_d.mask = bus_wdata[ID_W-1:0];
                    OFS_EOI: begin
                        if (ctl_q.run_id != NO_IRQ) begin
                            if (eoi_id == ctl_q.run_id) begin
                                ctl_d.run_id   = lt_rdata_a.id;
                                ctl_d.run_prio = (lt_rdata_a.id == NO_IRQ) ? IDLE_PRIO
                                                                           : lt_rdata_a.prio;
                            end else begin
                                ctl_d.st  = ST_WALK;
                                ctl_d.cur = ctl_q.run_id;
                                ctl_d.tgt = eoi_id;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end else begin
            if (lt_rdata_a.id == NO_IRQ) begin
                ctl_d.st = ST_IDLE;
            end else if (lt_rdata_a.id == ctl_q.tgt) begin
                lt_we    = 1'b1;
                lt_waddr = ctl_q.cur;
                lt_wdata = lt_rdata_b;
                ctl_d.st = ST_IDLE;
            end else begin
                ctl_d.cur = lt_rdata_a.id;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, en: 1'b0, mask: MASK_RST, run_id: NO_IRQ,
                       run_prio: IDLE_PRIO, cur: NO_IRQ, tgt: NO_IRQ};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_en    = ctl_q.en;
    assign prio_mask = ctl_q.mask;
    assign run_id    = ctl_q.run_id;
    assign run_prio  = ctl_q.run_prio;

    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == NO_IRQ) |-> (run_prio == IDLE_PRIO)); // R5

    AST_CLAIM_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |=> (run_id == $past(claim_id)) && (run_prio < $past(run_prio))); // R3

    AST_REFUSE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !bus_write && ofs == OFS_ACK && !claim_valid)
            |-> (bus_rdata == DATA_W'(NO_IRQ))); // R4

    AST_EOI_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_write && ofs == OFS_EOI && run_id == NO_IRQ)
            |=> (run_id == NO_IRQ) && bus_ready); // R6

    AST_WALK_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> $stable(run_id) && $stable(run_prio)); // R8
endmodule

// File: tb/irq_ack_tracker_tb.sv
`timescale 1ns/1ps
module irq_ack_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [9:0]  pend_id = 10'd1023;
    logic [7:0]  pend_prio = 8'hFF;
    logic        claim_valid;
    logic [9:0]  claim_id;
    logic        cpu_en;
    logic [9:0]  prio_mask, run_id;
    logic [8:0]  run_prio;

    int n_chk = 0, n_fail = 0;
    logic [31:0] rd;
    logic        cl;
    logic [9:0]  cid;

    always #2.5 clk = ~clk;

    irq_ack_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .pend_id(pend_id), .pend_prio(pend_prio),
        .claim_valid(claim_valid), .claim_id(claim_id), .cpu_en(cpu_en),
        .prio_mask(prio_mask), .run_id(run_id), .run_prio(run_prio)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        #1;
        rd = bus_rdata; cl = claim_valid; cid = claim_id;
        @(posedge clk);
        #0.5;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic busy_count(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (!bus_ready) n++;
            else break;
        end
    endtask

    task automatic claim(input int id, input int pr, input string tag);
        pend_id = 10'(id); pend_prio = 8'(pr);
        access(1'b0, 8'h0C, 32'h0);
        chk({tag, " ack data"}, int'(rd), id);
        chk({tag, " claim pulse"}, int'(cl), 1);
        chk({tag, " claim id"}, int'(cid), id);
        @(negedge clk);
        chk({tag, " run id"}, int'(run_id), id);
        chk({tag, " run prio"}, int'(run_prio), pr);
    endtask

    task automatic eoi(input int id, input int exp_busy, input int exp_id, input int exp_pr,
                       input string tag);
        int nb;
        access(1'b1, 8'h10, 32'hABCD_E000 | 32'(id));
        busy_count(nb);
        chk({tag, " busy cycles"}, nb, exp_busy);
        chk({tag, " run id"}, int'(run_id), exp_id);
        chk({tag, " run prio"}, int'(run_prio), exp_pr);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 run id", int'(run_id), 1023);
        chk("R1 run prio", int'(run_prio), 256);
        chk("R1 mask", int'(prio_mask), 'hF0);
        chk("R1 enable", int'(cpu_en), 0);
        chk("R1 ready", int'(bus_ready), 1);
    endtask

    task automatic t_regs();
        access(1'b1, 8'h00, 32'h0000_0003);
        @(negedge clk);
        chk("R2 enable port", int'(cpu_en), 1);
        access(1'b0, 8'h00, 32'h0);
        chk("R2 enable read", int'(rd), 1);
        access(1'b1, 8'h04, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R2 mask port", int'(prio_mask), 'h3FF);
        access(1'b0, 8'h04, 32'h0);
        chk("R2 mask read", int'(rd), 'h3FF);
        pend_id = 10'd37;
        access(1'b0, 8'h18, 32'h0);
        chk("R2 pending read", int'(rd), 37);
        access(1'b0, 8'h14, 32'h0);
        chk("R2 run prio read", int'(rd), 256);
    endtask

    task automatic refuse(input int id, input int pr, input string tag);
        int rid, rpr;
        rid = int'(run_id); rpr = int'(run_prio);
        pend_id = 10'(id); pend_prio = 8'(pr);
        access(1'b0, 8'h0C, 32'h0);
        chk({tag, " data"}, int'(rd), 1023);
        chk({tag, " no claim"}, int'(cl), 0);
        @(negedge clk);
        chk({tag, " run id kept"}, int'(run_id), rid);
        chk({tag, " run prio kept"}, int'(run_prio), rpr);
    endtask

    task automatic t_nest_out_of_order();
        claim(40, 'h80, "R3 first");
        claim(12, 'h40, "R3 second");
        claim(70, 'h20, "R3 third");
        refuse(5, 'h20, "R4 equal prio");
        refuse(1023, 0, "R4 none pending");
        refuse(100, 0, "R4 id out of range");
        eoi(12, 1, 70, 'h20, "R8 retire middle");
        eoi(70, 0, 40, 'h80, "R7 pop skips retired");
        eoi(40, 0, 1023, 256, "R5 pop to idle");
    endtask

    task automatic t_eoi_idle();
        eoi(40, 0, 1023, 256, "R6 eoi with none active");
        access(1'b0, 8'h14, 32'h0);
        chk("R6 run prio read", int'(rd), 256);
    endtask

    task automatic t_not_in_chain();
        claim(3, 'h90, "R3 base");
        claim(9, 'h10, "R3 top");
        eoi(50, 2, 9, 'h10, "R9 miss walk");
        eoi(9, 0, 3, 'h90, "R7 pop after miss");
        eoi(3, 0, 1023, 256, "R7 pop to idle");
    endtask

    task automatic t_deep_splice();
        claim(20, 'h60, "R3 a");
        claim(21, 'h50, "R3 b");
        claim(22, 'h40, "R3 c");
        eoi(20, 2, 22, 'h40, "R8 retire bottom");
        eoi(22, 0, 21, 'h50, "R7 pop c");
        eoi(21, 0, 1023, 256, "R8 bottom skipped");
    endtask

    initial begin
        #20000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_nest_out_of_order();
        t_eoi_idle();
        t_not_in_chain();
        t_deep_splice();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule